// File: doc/BRIEF.md
# Reduced Four-Class Serial Mealy Recognizer

This block is a synchronous Mealy machine that watches a one-bit serial input `x` and produces a one-bit output `z`. Its behaviour matches an eight-state transition/output table. At design time that table was reduced to four equivalence classes, so the hardware holds only two bits of state in binary form, or four bits in one-hot form. The output is a combinational function of the current class and the present value of `x`, so `z` answers in the same cycle that `x` is applied.

Class A holds the lone state that emits 1 on a zero input. Class B is the state that always emits 0 and returns to A. Class C merges the two states that step back to B. Class D merges the four states that emit 1 on a one input. A `1` on `x` always moves the machine to D, whatever class it is in. A `0` moves it one class back along the path D→C→B→A, and A stays where it is. The machine is used as a drop-in sequence classifier. The parameter `ONE_HOT` picks the storage encoding of the class register and has no effect on behaviour at the pins.

Top module: `min_mealy_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the class register is loaded with class A. On the first cycle after release, `x`=0 therefore gives `z`=1.
- R2: `z` depends combinationally on `x` within a cycle. A change of `x` between edges changes `z` before the next edge, with no register in the path.
- R3: From any class, `x`=1 at a rising edge moves the machine to class D. A following `x`=1 therefore gives `z`=1.
- R4: In class A with `x`=0, `z` is 1 and the machine stays in A.
- R5: In class B with `x`=0, `z` is 0 and the next class is A.
- R6: In class C with `x`=0, `z` is 0 and the next class is B.
- R7: In class D, `x`=0 gives `z`=0 with next class C. `x`=1 gives `z`=1 with the machine staying in D.
- R8: `z` is 0 for every other class/input pair: A with `x`=1, and B or C with any `x`.
- R9: For every input stream, `z` equals, cycle by cycle, the output of the unreduced eight-state table started in its first state. This holds for both `ONE_HOT`=0 and `ONE_HOT`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to class A |
| x | input | 1 | Serial input bit, sampled at each rising edge |
| z | output | 1 | Mealy output, combinational from class and `x` |

## Verification
The checker properties assume that `x` is settled at every rising edge and that `rst` is synchronous. They are disabled while `rst` is high, so a transition is only judged when it starts in a cycle where reset is low. The bench changes `x` only on falling edges and samples `z` shortly afterwards, so every sample falls well away from the active edge. The one exception is the R2 probe, which changes `x` a second time in the middle of the low phase. The bench also pulses reset in the middle of a run, to show that reset recovery lands in class A from a state other than the initial one.

// File: rtl/mealy_pkg.sv
package mealy_pkg;
  localparam int NUM_CLS = 4;
  localparam int CLS_W   = $clog2(NUM_CLS);

  typedef enum logic [CLS_W-1:0] {
    CLS_A = 2'd0,
    CLS_B = 2'd1,
    CLS_C = 2'd2,
    CLS_D = 2'd3
  } cls_e;
endpackage

// File: rtl/seq_next.sv
module seq_next
  import mealy_pkg::*;
(
  input  cls_e cur,
  input  logic x,
  output cls_e nxt
);
  always_comb begin
    if (x) begin
      nxt = CLS_D;
    end else begin
      unique case (cur)
        CLS_A:   nxt = CLS_A;
        CLS_B:   nxt = CLS_A;
        CLS_C:   nxt = CLS_B;
        CLS_D:   nxt = CLS_C;
        default: nxt = CLS_A;
      endcase
    end
  end
endmodule

// File: rtl/seq_out.sv
module seq_out
  import mealy_pkg::*;
(
  input  cls_e cur,
  input  logic x,
  output logic z
);
  // only two class/input pairs raise the output
  always_comb begin
    z = 1'b0;
    if (!x && cur == CLS_A) z = 1'b1;
    if ( x && cur == CLS_D) z = 1'b1;
  end
endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg
  import mealy_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  cls_e nxt,
  output cls_e cur
);
  generate
    if (ONE_HOT) begin : g_hot
      logic [NUM_CLS-1:0] hot;
      localparam logic [NUM_CLS-1:0] HOT_ONE = {{(NUM_CLS-1){1'b0}}, 1'b1};

      always_ff @(posedge clk) begin
        if (rst) hot <= HOT_ONE << CLS_A;
        else     hot <= HOT_ONE << nxt;
      end

      always_comb begin
        cur = CLS_A;
        for (int i = 0; i < NUM_CLS; i++) begin
          if (hot[i]) cur = cls_e'(CLS_W'(i));
        end
      end
    end else begin : g_bin
      cls_e st;

      always_ff @(posedge clk) begin
        if (rst) st <= CLS_A;
        else     st <= nxt;
      end

      assign cur = st;
    end
  endgenerate
endmodule

// File: rtl/min_mealy_fsm.sv
module min_mealy_fsm
  import mealy_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic z
);
  cls_e cur_cls;
  cls_e nxt_cls;

  seq_state_reg #(.ONE_HOT(ONE_HOT)) u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_cls),
    .cur (cur_cls)
  );

  seq_next u_next (
    .cur (cur_cls),
    .x   (x),
    .nxt (nxt_cls)
  );

  seq_out u_out (
    .cur (cur_cls),
    .x   (x),
    .z   (z)
  );
endmodule

// File: rtl/min_mealy_chk.sv
module min_mealy_chk
  import mealy_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic x,
  input logic z,
  input cls_e cur
);
  // R3
  one_to_d_chk: assert property (@(posedge clk) disable iff (rst)
    x |=> cur == CLS_D);

  // R4
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!x && cur == CLS_A) |=> cur == CLS_A);

  // R5
  b_back_chk: assert property (@(posedge clk) disable iff (rst)
    (!x && cur == CLS_B) |=> cur == CLS_A);

  // R6
  c_back_chk: assert property (@(posedge clk) disable iff (rst)
    (!x && cur == CLS_C) |=> cur == CLS_B);

  // R7
  d_back_chk: assert property (@(posedge clk) disable iff (rst)
    (!x && cur == CLS_D) |=> cur == CLS_C);

  // R8
  z_high_one_chk: assert property (@(posedge clk) disable iff (rst)
    (z && x) |-> cur == CLS_D);

  // R8
  z_high_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (z && !x) |-> cur == CLS_A);
endmodule

bind min_mealy_fsm min_mealy_chk u_chk (
  .clk (clk),
  .rst (rst),
  .x   (x),
  .z   (z),
  .cur (cur_cls)
);

// File: tb/sim_min_mealy_fsm.sv
`timescale 1ns/1ps
module sim_min_mealy_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic z, z_hot;

  int checks = 0;
  int errors = 0;
  int rs     = 0;
  bit prev_x = 1'b0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  min_mealy_fsm #(.ONE_HOT(1'b0)) u0 (.clk(clk), .rst(rst), .x(x), .z(z));
  min_mealy_fsm #(.ONE_HOT(1'b1)) u1 (.clk(clk), .rst(rst), .x(x), .z(z_hot));

  // unreduced eight-state table
  function automatic int ref_nxt(int s, bit xv);
    case (s)
      0, 1:    return xv ? 4 : 0;
      2, 3:    return xv ? 5 : 1;
      4, 5:    return xv ? 6 : 2;
      default: return xv ? 7 : 3;
    endcase
  endfunction

  function automatic bit ref_out(int s, bit xv);
    if (s == 0) return !xv;
    if (s >= 4) return xv;
    return 1'b0;
  endfunction

  function automatic string tag_of(int s, bit xv, bit px);
    if (px && xv)           return "R3";
    if (s == 0 && !xv)      return "R4";
    if (s == 1 && !xv)      return "R5";
    if (s inside {2,3} && !xv) return "R6";
    if (s >= 4)             return "R7";
    return "R8";
  endfunction

  task automatic chk(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b state=%0d t=%0t", tag, act, exp, rs, $time);
    end
  endtask

  // one cycle: drive x on the falling edge, sample, then advance the model
  task automatic step(bit xv, string force_tag = "");
    string t;
    @(negedge clk);
    x = xv;
    #2;
    if (!rst) begin
      t = (force_tag != "") ? force_tag : tag_of(rs, xv, prev_x);
      chk(t, z, ref_out(rs, xv));
      chk("R9", z_hot, ref_out(rs, xv));
    end
    @(posedge clk);
    if (rst) begin
      rs = 0;
      prev_x = 1'b0;
    end else begin
      rs = ref_nxt(rs, xv);
      prev_x = xv;
    end
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    rst = 1'b1;
    repeat (n) step(1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    bit [15:0] lfsr;
    do_reset(3);
    step(1'b0, "R1");                 // class A right after reset
    // R2: same cycle, toggle x between edges
    @(negedge clk);
    x = 1'b0; #2; chk("R2", z, 1'b1);
    x = 1'b1; #2; chk("R2", z, 1'b0);
    x = 1'b0; #2; chk("R2", z, 1'b1);
    @(posedge clk);
    rs = ref_nxt(rs, 1'b0); prev_x = 1'b0;
    // walk D -> C -> B -> A, then A hold
    step(1'b1); step(1'b1); step(1'b1);
    step(1'b0); step(1'b0); step(1'b0); step(1'b0); step(1'b0);
    // R3 from each class: B, C, D and A
    step(1'b1); step(1'b0); step(1'b0); step(1'b1); step(1'b1);
    step(1'b0); step(1'b1); step(1'b1);
    step(1'b0); step(1'b0); step(1'b0); step(1'b1); step(1'b0);
    step(1'b0); step(1'b0); step(1'b0);
    // mid-run reset from class D
    step(1'b1); step(1'b1);
    do_reset(1);
    step(1'b0, "R1");
    // alternating pattern
    for (int i = 0; i < 40; i++) step(i[0]);
    // pseudo-random stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[3]);
    end
    for (int i = 0; i < 500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5]);
    end
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule